// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block is a small shared word memory that several requesters use to build atomic read-modify-write sequences without an indivisible swap. A requester issues a load-linked to read a word and place a reservation on its address. It then issues a store-conditional to the same address. The write lands only if no other requester has stored to that word in between. The store-conditional reports success or failure, and software retries the whole sequence on failure. Exchange and fetch-and-increment are built this way.

Plain loads and plain stores are accepted as well. Any store that commits, plain or conditional, breaks the reservations that other requesters hold on that address. A fixed-priority arbiter accepts one request per cycle, with the lowest requester index first. The response returns on the cycle after the grant.

Top module: `llsc_monitor`

## Requirements
- R1: Each requester encodes its operation on 2 bits: 0 = plain load, 1 = load-linked, 2 = plain store, 3 = store-conditional. A granted load or load-linked returns the current memory word on rsp_data, with rsp_ok=1. The response appears with rsp_valid=1 and rsp_id set to the requester, in the cycle after the grant.
- R2: A load-linked sets that requester's reservation to the address. A later store-conditional from the same requester to that address, with the reservation still intact, writes the word and responds rsp_ok=1 with rsp_data=1.
- R3: A store-conditional that fails responds rsp_ok=0 with rsp_data=0, and leaves memory unchanged.
- R4: A committed store to an address clears every other requester's reservation on that address. This holds for a plain store and for a successful store-conditional.
- R5: A store to a different address leaves a reservation intact.
- R6: A store-conditional always clears the issuer's own reservation, whether it passes or fails. A second store-conditional without a new load-linked fails. A store-conditional to an address other than the reserved one fails.
- R7: At most one requester is granted per cycle (gnt one-hot or zero). Only a requesting index is granted, and the lowest requesting index wins.
- R8: After reset there is no response and no grant without requests. All memory words read 0, and no reservation exists, so a store-conditional fails.
- R9: A plain store writes the word and responds rsp_ok=1 with rsp_data=0.
- R10: A load-linked / store-conditional retry loop gives a correct atomic exchange and a correct fetch-and-increment when requesters contend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request pending, one bit per requester |
| req_op | input | 2*NREQ | Operation code per requester (field i at bits 2i+1:2i) |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write data per requester |
| gnt | output | NREQ | Requester accepted this cycle (combinational) |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IDW | Requester the response belongs to |
| rsp_data | output | DW | Read word, or success flag for a store-conditional |
| rsp_ok | output | 1 | 0 only for a failed store-conditional |

## Verification
An uncontended pair that passes is compared with pairs broken by another requester's plain store and by another requester's successful store-conditional. A store to a neighbouring address tells a real conflict apart from a reservation that is cleared too eagerly. Repeated store-conditionals, store-conditionals with no load-linked and store-conditionals to a mismatched address show that the issuer's own reservation is consumed. Requests raised in the same cycle show the priority order. Contended exchange and increment loops show the final memory value that the retries produce.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_LL    = 2'd1,
        OP_STORE = 2'd2,
        OP_SC    = 2'd3
    } llsc_op_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
    parameter int NREQ = 4,
    parameter int IDW  = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt,
    output logic [IDW-1:0]  gid,
    output logic            any
);
    always_comb begin
        gnt = '0;
        gid = '0;
        any = 1'b0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                gid = IDW'(i);
                any = 1'b1;
            end
        end
        if (any) gnt[gid] = 1'b1;
    end

    p_gnt_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
    p_gnt_requested_r7: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
    p_gnt_when_req_r7: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|gnt));
endmodule

// File: rtl/llsc_store.sv
module llsc_store #(
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] mem;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) s_d.mem[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.mem[raddr];

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> s_q.mem[$past(waddr)] == $past(wdata));
    p_no_write_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> s_q.mem[$past(raddr)] == $past(rdata));
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv
    import llsc_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int IDW  = $clog2(NREQ)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act,
    input  logic [IDW-1:0] act_id,
    input  llsc_op_e       act_op,
    input  logic [AW-1:0]  act_addr,
    output logic           sc_pass,
    output logic           commit
);
    typedef struct packed {
        logic [NREQ-1:0]         v;
        logic [NREQ-1:0][AW-1:0] a;
    } resv_t;

    resv_t r_d, r_q;

    assign sc_pass = act && (act_op == OP_SC) && r_q.v[act_id] && (r_q.a[act_id] == act_addr);
    assign commit  = act && ((act_op == OP_STORE) || sc_pass);

    always_comb begin
        r_d = r_q;
        if (commit) begin
            for (int k = 0; k < NREQ; k++) begin
                if (IDW'(k) != act_id && r_q.a[k] == act_addr) r_d.v[k] = 1'b0;
            end
        end
        if (act && act_op == OP_LL) begin
            r_d.v[act_id] = 1'b1;
            r_d.a[act_id] = act_addr;
        end
        if (act && act_op == OP_SC) r_d.v[act_id] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_ll_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act && act_op == OP_LL) |=> r_q.v[$past(act_id)] && r_q.a[$past(act_id)] == $past(act_addr));
    p_sc_clears_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && act_op == OP_SC) |=> !r_q.v[$past(act_id)]);

    for (genvar k = 0; k < NREQ; k++) begin : g_chk
        p_store_breaks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && act_id != IDW'(k) && r_q.a[k] == act_addr) |=> !r_q.v[k]);
        p_other_addr_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (act && act_op != OP_SC && r_q.v[k] && r_q.a[k] != act_addr) |=> r_q.v[k]);
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int DW   = 32,
    parameter int IDW  = $clog2(NREQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_valid,
    input  logic [2*NREQ-1:0]    req_op,
    input  logic [AW*NREQ-1:0]   req_addr,
    input  logic [DW*NREQ-1:0]   req_wdata,
    output logic [NREQ-1:0]      gnt,
    output logic                 rsp_valid,
    output logic [IDW-1:0]       rsp_id,
    output logic [DW-1:0]        rsp_data,
    output logic                 rsp_ok
);
    typedef struct packed {
        logic           valid;
        logic [IDW-1:0] id;
        logic [DW-1:0]  data;
        logic           ok;
    } rsp_t;

    rsp_t o_d, o_q;

    logic [IDW-1:0] gid;
    logic           any;
    llsc_op_e       g_op;
    logic [AW-1:0]  g_addr;
    logic [DW-1:0]  g_wdata;
    logic [DW-1:0]  rdata;
    logic           sc_pass;
    logic           commit;

    llsc_arbiter #(.NREQ(NREQ), .IDW(IDW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid), .gnt(gnt), .gid(gid), .any(any)
    );

    assign g_op    = llsc_op_e'(req_op[gid*2 +: 2]);
    assign g_addr  = req_addr[gid*AW +: AW];
    assign g_wdata = req_wdata[gid*DW +: DW];

    llsc_resv #(.NREQ(NREQ), .AW(AW), .IDW(IDW)) u_resv (
        .clk(clk), .rst_n(rst_n), .act(any), .act_id(gid), .act_op(g_op),
        .act_addr(g_addr), .sc_pass(sc_pass), .commit(commit)
    );

    llsc_store #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(g_addr), .wdata(g_wdata),
        .raddr(g_addr), .rdata(rdata)
    );

    always_comb begin
        o_d       = '0;
        o_d.valid = any;
        o_d.id    = gid;
        o_d.ok    = 1'b1;
        case (g_op)
            OP_LOAD, OP_LL: o_d.data = rdata;
            OP_STORE:       o_d.data = '0;
            OP_SC: begin
                o_d.data = DW'(sc_pass);
                o_d.ok   = sc_pass;
            end
            default:        o_d.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rsp_valid = o_q.valid;
    assign rsp_id    = o_q.id;
    assign rsp_data  = o_q.data;
    assign rsp_ok    = o_q.ok;

    p_rsp_follows_gnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> rsp_valid);
    p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> !rsp_valid);
    p_failed_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (any && g_op == OP_SC && !commit) |=> (!rsp_ok && rsp_data == '0));
endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 4;
    localparam int AW   = 4;
    localparam int DW   = 32;
    localparam int IDW  = 2;
    localparam int WORDS = 1 << AW;

    logic clk = 0;
    logic rst_n = 0;
    logic [NREQ-1:0]    req_valid = '0;
    logic [2*NREQ-1:0]  req_op = '0;
    logic [AW*NREQ-1:0] req_addr = '0;
    logic [DW*NREQ-1:0] req_wdata = '0;
    logic [NREQ-1:0]    gnt;
    logic               rsp_valid;
    logic [IDW-1:0]     rsp_id;
    logic [DW-1:0]      rsp_data;
    logic               rsp_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW), .IDW(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
    );

    typedef struct {
        int          id;
        logic [31:0] data;
        logic        ok;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          failures = 0;
    logic [31:0] last_data;
    logic [31:0] m_mem [WORDS];
    logic        m_rv [NREQ];
    logic [AW-1:0] m_ra [NREQ];
    int          b_op [NREQ];
    int          b_addr [NREQ];
    logic [31:0] b_wd [NREQ];
    string       b_tag [NREQ];

    task automatic check(input bit cond, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(0, "R1", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(rsp_id) == e.id, e.tag, "rsp_id", rsp_id, e.id);
                check(rsp_data == e.data, e.tag, "rsp_data", rsp_data, e.data);
                check(rsp_ok == e.ok, e.tag, "rsp_ok", rsp_ok, e.ok);
            end
            last_data = rsp_data;
        end
    end

    task automatic model(input int id);
        exp_t e;
        logic [AW-1:0] a;
        logic pass;
        a = AW'(b_addr[id]);
        e.id = id; e.tag = b_tag[id]; e.ok = 1'b1; e.data = '0;
        case (b_op[id])
            0: e.data = m_mem[a];
            1: begin e.data = m_mem[a]; m_rv[id] = 1'b1; m_ra[id] = a; end
            2: begin
                m_mem[a] = b_wd[id];
                for (int k = 0; k < NREQ; k++) if (k != id && m_ra[k] == a) m_rv[k] = 1'b0;
            end
            default: begin
                pass = m_rv[id] && m_ra[id] == a;
                if (pass) begin
                    m_mem[a] = b_wd[id];
                    for (int k = 0; k < NREQ; k++) if (k != id && m_ra[k] == a) m_rv[k] = 1'b0;
                end
                m_rv[id] = 1'b0;
                e.data = {31'd0, pass};
                e.ok = pass;
            end
        endcase
        sb.push_back(e);
    endtask

    task automatic set_req(input int id, input int op, input int addr,
                           input logic [31:0] wd, input string tag);
        b_op[id] = op; b_addr[id] = addr; b_wd[id] = wd; b_tag[id] = tag;
        req_op[id*2 +: 2] = 2'(op);
        req_addr[id*AW +: AW] = AW'(addr);
        req_wdata[id*DW +: DW] = wd;
        req_valid[id] = 1'b1;
    endtask

    task automatic run();
        while (req_valid != '0) begin
            int low;
            logic [NREQ-1:0] expg;
            #1;
            low = 0;
            for (int i = NREQ - 1; i >= 0; i--) if (req_valid[i]) low = i;
            expg = '0;
            expg[low] = 1'b1;
            check(gnt == expg, "R7", "gnt", gnt, expg);
            model(low);
            @(posedge clk);
            @(negedge clk);
            req_valid[low] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic one(input int id, input int op, input int addr,
                       input logic [31:0] wd, input string tag);
        set_req(id, op, addr, wd, tag);
        run();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
        for (int i = 0; i < NREQ; i++) begin m_rv[i] = 0; m_ra[i] = '0; end
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "rsp_valid in reset", rsp_valid, 0);
        check(gnt == '0, "R8", "gnt idle in reset", gnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "rsp_valid after reset", rsp_valid, 0);

        one(0, 0, 3, 0, "R8");
        one(1, 3, 3, 32'h55, "R8");
        one(2, 0, 3, 0, "R8");

        one(0, 2, 5, 32'hA5A5, "R9");
        one(1, 0, 5, 0, "R1");
        one(1, 1, 5, 0, "R1");
        one(1, 3, 5, 32'h1234, "R2");
        one(2, 0, 5, 0, "R2");

        one(0, 1, 6, 0, "R4");
        one(2, 2, 6, 32'h66, "R4");
        one(0, 3, 6, 32'h77, "R3");
        one(3, 0, 6, 0, "R3");

        one(0, 1, 7, 0, "R4");
        one(1, 1, 7, 0, "R4");
        one(1, 3, 7, 32'h71, "R4");
        one(0, 3, 7, 32'h70, "R4");
        one(2, 0, 7, 0, "R4");

        one(0, 1, 8, 0, "R5");
        one(1, 2, 9, 32'h99, "R5");
        one(0, 0, 8, 0, "R5");
        one(0, 3, 8, 32'h88, "R5");

        one(3, 1, 10, 0, "R6");
        one(3, 2, 10, 32'h10, "R6");
        one(3, 3, 10, 32'hA1, "R6");
        one(3, 3, 10, 32'hA2, "R6");
        one(3, 1, 11, 0, "R6");
        one(3, 3, 12, 32'hC0, "R6");
        one(3, 0, 12, 0, "R6");

        set_req(3, 2, 13, 32'h7, "R7");
        set_req(1, 1, 13, 0, "R7");
        set_req(0, 0, 13, 0, "R7");
        set_req(2, 3, 13, 32'h2, "R7");
        run();
        one(1, 3, 13, 32'h8, "R4");

        one(0, 1, 14, 0, "R10");
        one(1, 1, 14, 0, "R10");
        one(1, 3, 14, 32'd1, "R10");
        one(0, 3, 14, 32'd1, "R10");
        one(0, 1, 14, 0, "R10");
        one(0, 3, 14, 32'd2, "R10");
        one(2, 0, 14, 0, "R10");
        check(last_data == 32'd2, "R10", "fetch-increment final", last_data, 2);

        one(2, 2, 15, 32'd5, "R10");
        one(2, 1, 15, 0, "R10");
        check(last_data == 32'd5, "R10", "exchange old value", last_data, 5);
        one(2, 3, 15, 32'd9, "R10");
        one(3, 0, 15, 0, "R10");
        check(last_data == 32'd9, "R10", "exchange new value", last_data, 9);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1", "missing responses", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule